// File: doc/BRIEF.md
# Processor Operating Mode Decoder

This block collapses scattered architectural control state into a single cached mode word. It watches the extended feature register, control register 0, the code-segment and stack-segment attribute bytes and the flags register. From them it derives the major mode (legacy or long), a sub-mode, the current privilege level, the paging enable, the default and alternate operand and address sizes, and the stack size. The downstream pipeline then reads one registered word and does not re-decode the individual registers.

The word is held in a register. It is reloaded on the clock edge that follows any change on any of the watched inputs. It is also reloaded when the explicit refresh strobe is high. Between such events it holds its value. The sub-mode follows a fixed priority: within legacy mode, the virtual-8086 flag wins over protection enable. Every size output is coded as a byte count: 2, 4 or 8.

Top module: `cpu_mode_decoder`

## Requirements
- R1: `mode_long` is 1 exactly when bit 10 of `feat_reg` (long mode active) is set. The code-segment long bit and the flags VM bit do not select the major mode.
- R2: In long mode, `sub_mode` is 4 (64-bit) when code-segment attribute bit 2 (long) is set, and 3 (compatibility) otherwise.
- R3: In legacy mode, `sub_mode` is 2 (virtual-8086) when `flags` bit 17 is set. Otherwise it is 1 (protected) when `ctl0` bit 0 is set. Otherwise it is 0 (real). Bit 17 has priority over bit 0.
- R4: `cpl` equals code-segment attribute bits [1:0].
- R5: `paging` equals `ctl0` bit 31.
- R6: `op_def` is 4 when the sub-mode is 64-bit or code-segment attribute bit 3 (default size) is set, and 2 otherwise. `op_alt` is 8 in 64-bit sub-mode. Otherwise `op_alt` is the other of 2 and 4, so it never equals `op_def`.
- R7: `addr_def` is 8 in 64-bit sub-mode. Otherwise it is 4 when code-segment attribute bit 3 is set, and 2 when it is clear. `addr_alt` is 4 in 64-bit sub-mode, and the other of 2 and 4 elsewhere.
- R8: `stack_sz` is 8 in 64-bit sub-mode. Otherwise it is 4 when stack-segment attribute bit 3 is set, and 2 when it is clear.
- R9: The outputs take the decoded value of the inputs one clock edge after an input change or a `refresh` pulse. With no change and no refresh they hold. A refresh with unchanged inputs, or a change to a bit that no rule reads, leaves every output value the same.
- R10: While `rst` is high, the outputs read legacy mode, sub-mode 0, `cpl` 0, `paging` 0, `op_def` 2, `op_alt` 4, `addr_def` 2, `addr_alt` 4, `stack_sz` 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| refresh | input | 1 | Forces a reload of the mode word on the next edge |
| feat_reg | input | XLEN | Extended feature register |
| ctl0 | input | XLEN | Control register 0 |
| cs_attr | input | ATTR_W | Code-segment attribute byte |
| ss_attr | input | ATTR_W | Stack-segment attribute byte |
| flags | input | XLEN | Flags register |
| mode_long | output | 1 | Major mode: 1 long, 0 legacy |
| sub_mode | output | 3 | 0 real, 1 protected, 2 virtual-8086, 3 compatibility, 4 64-bit |
| cpl | output | 2 | Current privilege level |
| paging | output | 1 | Paging enabled |
| op_def | output | 4 | Default operand size in bytes |
| op_alt | output | 4 | Alternate operand size in bytes |
| addr_def | output | 4 | Default address size in bytes |
| addr_alt | output | 4 | Alternate address size in bytes |
| stack_sz | output | 4 | Stack size in bytes |

## Verification
The change detector could miss an update, or the priority chain could be ordered wrongly. Either fault shows at the ports as a stale or wrong field on the sampling point one edge after the input change. The bench compares every field there. For example, a classifier that lets protection enable win over the VM flag reports sub-mode 1 instead of 2 in that first cycle. Bad size logic shows at once in 64-bit sub-mode, where the stack and address sizes must jump to 8.

// File: rtl/cmd_pkg.sv
package cmd_pkg;
  typedef enum logic [2:0] {
    SM_REAL      = 3'd0,
    SM_PROT      = 3'd1,
    SM_V86       = 3'd2,
    SM_COMPAT    = 3'd3,
    SM_SIXTYFOUR = 3'd4
  } submode_e;

  localparam int SZ_W = 4;
  localparam logic [SZ_W-1:0] SZ_2 = 4'd2;
  localparam logic [SZ_W-1:0] SZ_4 = 4'd4;
  localparam logic [SZ_W-1:0] SZ_8 = 4'd8;

  typedef struct packed {
    logic            long_mode;
    submode_e        sub;
    logic [1:0]      cpl;
    logic            paging;
    logic [SZ_W-1:0] op_def;
    logic [SZ_W-1:0] op_alt;
    logic [SZ_W-1:0] addr_def;
    logic [SZ_W-1:0] addr_alt;
    logic [SZ_W-1:0] stack_sz;
  } mode_word_t;

  localparam mode_word_t MODE_WORD_RESET = '{
    long_mode: 1'b0, sub: SM_REAL, cpl: 2'd0, paging: 1'b0,
    op_def: SZ_2, op_alt: SZ_4, addr_def: SZ_2, addr_alt: SZ_4, stack_sz: SZ_2
  };
endpackage

// File: rtl/cmd_mode_classify.sv
module cmd_mode_classify
  import cmd_pkg::*;
(
  input  logic     lma,
  input  logic     cs_long,
  input  logic     vm,
  input  logic     pe,
  output logic     long_mode,
  output submode_e sub
);
  always_comb begin
    long_mode = lma;
    if (lma) begin
      sub = cs_long ? SM_SIXTYFOUR : SM_COMPAT;
    end else if (vm) begin
      sub = SM_V86;
    end else if (pe) begin
      sub = SM_PROT;
    end else begin
      sub = SM_REAL;
    end
  end
endmodule

// File: rtl/cmd_size_select.sv
module cmd_size_select
  import cmd_pkg::*;
(
  input  submode_e        sub,
  input  logic            cs_dsize,
  input  logic            ss_dsize,
  output logic [SZ_W-1:0] op_def,
  output logic [SZ_W-1:0] op_alt,
  output logic [SZ_W-1:0] addr_def,
  output logic [SZ_W-1:0] addr_alt,
  output logic [SZ_W-1:0] stack_sz
);
  logic wide;
  assign wide = (sub == SM_SIXTYFOUR);

  always_comb begin
    if (wide) begin
      op_def   = SZ_4;
      op_alt   = SZ_8;
      addr_def = SZ_8;
      addr_alt = SZ_4;
      stack_sz = SZ_8;
    end else begin
      op_def   = cs_dsize ? SZ_4 : SZ_2;
      op_alt   = cs_dsize ? SZ_2 : SZ_4;
      addr_def = cs_dsize ? SZ_4 : SZ_2;
      addr_alt = cs_dsize ? SZ_2 : SZ_4;
      stack_sz = ss_dsize ? SZ_4 : SZ_2;
    end
  end
endmodule

// File: rtl/cmd_change_detect.sv
module cmd_change_detect #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         refresh,
  input  logic [W-1:0] vec,
  output logic         load
);
  logic [W-1:0] snap_q;

  always_ff @(posedge clk) begin
    if (rst) snap_q <= '0;
    else     snap_q <= vec;
  end

  assign load = refresh | (|(vec ^ snap_q));
endmodule

// File: rtl/cpu_mode_decoder.sv
module cpu_mode_decoder
  import cmd_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int ATTR_W    = 8,
  parameter int LMA_BIT   = 10,
  parameter int PE_BIT    = 0,
  parameter int PG_BIT    = 31,
  parameter int VM_BIT    = 17,
  parameter int DPL_LSB   = 0,
  parameter int LONG_BIT  = 2,
  parameter int DSIZE_BIT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              refresh,
  input  logic [XLEN-1:0]   feat_reg,
  input  logic [XLEN-1:0]   ctl0,
  input  logic [ATTR_W-1:0] cs_attr,
  input  logic [ATTR_W-1:0] ss_attr,
  input  logic [XLEN-1:0]   flags,
  output logic              mode_long,
  output logic [2:0]        sub_mode,
  output logic [1:0]        cpl,
  output logic              paging,
  output logic [SZ_W-1:0]   op_def,
  output logic [SZ_W-1:0]   op_alt,
  output logic [SZ_W-1:0]   addr_def,
  output logic [SZ_W-1:0]   addr_alt,
  output logic [SZ_W-1:0]   stack_sz
);
  localparam int VEC_W = 3 * XLEN + 2 * ATTR_W;

  logic       load;
  logic       nx_long;
  submode_e   nx_sub;
  mode_word_t nx_word;
  mode_word_t word_q;

  cmd_change_detect #(.W(VEC_W)) u_chg (
    .clk(clk), .rst(rst), .refresh(refresh),
    .vec({feat_reg, ctl0, flags, cs_attr, ss_attr}),
    .load(load)
  );

  cmd_mode_classify u_cls (
    .lma(feat_reg[LMA_BIT]), .cs_long(cs_attr[LONG_BIT]),
    .vm(flags[VM_BIT]), .pe(ctl0[PE_BIT]),
    .long_mode(nx_long), .sub(nx_sub)
  );

  cmd_size_select u_sz (
    .sub(nx_sub), .cs_dsize(cs_attr[DSIZE_BIT]), .ss_dsize(ss_attr[DSIZE_BIT]),
    .op_def(nx_word.op_def), .op_alt(nx_word.op_alt),
    .addr_def(nx_word.addr_def), .addr_alt(nx_word.addr_alt),
    .stack_sz(nx_word.stack_sz)
  );

  assign nx_word.long_mode = nx_long;
  assign nx_word.sub       = nx_sub;
  assign nx_word.cpl       = cs_attr[DPL_LSB +: 2];
  assign nx_word.paging    = ctl0[PG_BIT];

  always_ff @(posedge clk) begin
    if (rst)       word_q <= MODE_WORD_RESET;
    else if (load) word_q <= nx_word;
  end

  assign mode_long = word_q.long_mode;
  assign sub_mode  = word_q.sub;
  assign cpl       = word_q.cpl;
  assign paging    = word_q.paging;
  assign op_def    = word_q.op_def;
  assign op_alt    = word_q.op_alt;
  assign addr_def  = word_q.addr_def;
  assign addr_alt  = word_q.addr_alt;
  assign stack_sz  = word_q.stack_sz;

  assert_long_sub_R2: assert property (@(posedge clk) disable iff (rst)
    word_q.long_mode |-> (word_q.sub == SM_SIXTYFOUR || word_q.sub == SM_COMPAT));
  assert_legacy_sub_R3: assert property (@(posedge clk) disable iff (rst)
    !word_q.long_mode |-> (word_q.sub == SM_REAL || word_q.sub == SM_PROT || word_q.sub == SM_V86));
  assert_cpl_track_R4: assert property (@(posedge clk) disable iff (rst)
    (refresh && !rst) |=> (cpl == $past(cs_attr[DPL_LSB +: 2])));
  assert_paging_track_R5: assert property (@(posedge clk) disable iff (rst)
    (refresh && !rst) |=> (paging == $past(ctl0[PG_BIT])));
  assert_alt_differs_R6: assert property (@(posedge clk) disable iff (rst)
    word_q.op_alt != word_q.op_def);
  assert_wide_stack_R8: assert property (@(posedge clk) disable iff (rst)
    (word_q.sub == SM_SIXTYFOUR) |-> (word_q.stack_sz == SZ_8 && word_q.addr_def == SZ_8));
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!load && !rst) |=> $stable(word_q));
endmodule

// File: tb/sim_cpu_mode_decoder.sv
`timescale 1ns/1ps
module sim_cpu_mode_decoder;
  localparam int XLEN = 64;
  localparam int ATTR_W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, refresh;
  logic [XLEN-1:0] feat_reg, ctl0, flags;
  logic [ATTR_W-1:0] cs_attr, ss_attr;
  logic mode_long, paging;
  logic [2:0] sub_mode;
  logic [1:0] cpl;
  logic [3:0] op_def, op_alt, addr_def, addr_alt, stack_sz;

  cpu_mode_decoder u0 (
    .clk(clk), .rst(rst), .refresh(refresh), .feat_reg(feat_reg), .ctl0(ctl0),
    .cs_attr(cs_attr), .ss_attr(ss_attr), .flags(flags),
    .mode_long(mode_long), .sub_mode(sub_mode), .cpl(cpl), .paging(paging),
    .op_def(op_def), .op_alt(op_alt), .addr_def(addr_def), .addr_alt(addr_alt),
    .stack_sz(stack_sz)
  );

  typedef struct {
    int lm; int sub; int cpl; int pg;
    int opd; int opa; int ad; int aa; int st;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic exp_t model(bit lma, bit cl, bit cd, bit sd, bit vm, bit pe, bit pg, int dpl);
    exp_t e;
    e.lm  = lma;
    e.sub = lma ? (cl ? 4 : 3) : (vm ? 2 : (pe ? 1 : 0));
    e.cpl = dpl;
    e.pg  = pg;
    if (e.sub == 4) begin
      e.opd = 4; e.opa = 8; e.ad = 8; e.aa = 4; e.st = 8;
    end else begin
      e.opd = cd ? 4 : 2; e.opa = cd ? 2 : 4;
      e.ad  = cd ? 4 : 2; e.aa  = cd ? 2 : 4;
      e.st  = sd ? 4 : 2;
    end
    return e;
  endfunction

  task automatic drive(bit lma, bit cl, bit cd, bit sd, bit vm, bit pe, bit pg,
                       int dpl, bit junk, bit rf);
    @(negedge clk);
    feat_reg = '0; feat_reg[10] = lma; feat_reg[0] = junk;
    ctl0 = '0; ctl0[0] = pe; ctl0[31] = pg;
    flags = '0; flags[17] = vm; flags[1] = junk;
    cs_attr = '0; cs_attr[1:0] = dpl[1:0]; cs_attr[2] = cl; cs_attr[3] = cd; cs_attr[6] = junk;
    ss_attr = '0; ss_attr[3] = sd; ss_attr[5] = junk;
    refresh = rf;
    #1 q.push_back(model(lma, cl, cd, sd, vm, pe, pg, dpl));
    @(negedge clk);
    #2;
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk("R1 mode_long", mode_long, e.lm);
      chk(e.lm ? "R2 sub_mode" : "R3 sub_mode", sub_mode, e.sub);
      chk("R4 cpl", cpl, e.cpl);
      chk("R5 paging", paging, e.pg);
      chk("R6 op_def", op_def, e.opd);
      chk("R6 op_alt", op_alt, e.opa);
      chk("R7 addr_def", addr_def, e.ad);
      chk("R7 addr_alt", addr_alt, e.aa);
      chk("R8 stack_sz", stack_sz, e.st);
    end
  end

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; refresh = 1'b0;
    feat_reg = '0; feat_reg[10] = 1'b1; ctl0 = '1; flags = '0;
    cs_attr = 8'h0F; ss_attr = 8'h08;
    repeat (3) @(negedge clk);
    // R10: reset values while rst is high, whatever the inputs
    chk("R10 mode_long", mode_long, 0);
    chk("R10 sub_mode", sub_mode, 0);
    chk("R10 cpl", cpl, 0);
    chk("R10 paging", paging, 0);
    chk("R10 op_def", op_def, 2);
    chk("R10 op_alt", op_alt, 4);
    chk("R10 addr_def", addr_def, 2);
    chk("R10 addr_alt", addr_alt, 4);
    chk("R10 stack_sz", stack_sz, 2);
    rst = 1'b0;
    // lma, cs_long, cs_dsize, ss_dsize, vm, pe, pg, dpl, junk, refresh
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0); // R3 real
    drive(0, 0, 1, 0, 0, 1, 1, 3, 0, 0); // R3 protected, R4, R5
    drive(0, 0, 1, 1, 1, 1, 1, 3, 0, 0); // R3 VM over PE
    drive(0, 1, 0, 1, 0, 1, 0, 1, 0, 0); // R1 long bit ignored in legacy
    drive(1, 1, 0, 0, 0, 1, 1, 0, 0, 0); // R2 64-bit, R6 R7 R8
    drive(1, 1, 1, 1, 1, 1, 1, 2, 0, 0); // R1 VM ignored in long
    drive(1, 0, 0, 1, 0, 1, 1, 1, 0, 0); // R2 compatibility
    drive(1, 0, 1, 0, 0, 1, 0, 3, 0, 0); // R6 R7 compat with dsize
    drive(1, 0, 1, 0, 0, 1, 0, 3, 0, 1); // R9 refresh, same inputs
    drive(1, 0, 1, 0, 0, 1, 0, 3, 1, 0); // R9 unread bits toggled
    drive(0, 0, 0, 1, 0, 0, 1, 2, 0, 0); // R3 back to real
    begin
      // R9 hold: no change over several cycles
      repeat (3) @(negedge clk);
      chk("R9 hold sub_mode", sub_mode, 0);
      chk("R9 hold stack_sz", stack_sz, 4);
      chk("R9 hold cpl", cpl, 2);
    end
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule